// File: doc/BRIEF.md
# Sleep-State Rail Switch Sequencer

This block turns three active-high platform control lines into a power state: a power-good line, an S3 sleep request and an S5 sleep request. It then drives digital gate enables for two switched rails. The dual rail always carries power, from either the main supply or the standby supply. The adjustable rail is fed from main, fed from standby, or switched off. A separate enable marks when the main supply is in use. The analog comparators stay outside the block and report undervoltage on each rail as a digital flag.

Every input passes through a two-flop synchronizer. A newly decoded state must stay the same on two consecutive clocks before it is taken. The decode depends on history: the three codes that normally mean S3 are ignored while the block sits in S5, so S3 can only be reached through S0. Source handovers are timed in clock cycles. On the dual rail both gates are off for a dead time, and this dead time is longer when moving from main to standby than the other way. On the adjustable rail both drives are on for an overlap window. If a rail reports undervoltage continuously for a qualification window while it is driven, its overcurrent fault latches and its drives turn off. The latch clears only when standby power is lost. While the standby-good input is low, every output is held off, and the block restarts in S5.

With the default parameters the block expects a 2 MHz tick. This gives 4 µs of main-to-standby dead time, 500 ns of standby-to-main dead time, 3 µs of overlap and 150 µs of fault qualification.

Top module: `acpi_pwr_seq`

## Requirements
- R1: After synchronization, the code {pwr_ok_i, slp_s3_i, slp_s5_i} maps to a state as follows. 111 gives S0 (state_o=2). 101, 011 and 001 give S3 (state_o=1). 100, 010 and 000 give S5 (state_o=0). 110 gives the unused state (state_o=3). main_en_o is high only in S0 and in the unused state.
- R2: While in S5, the codes 101, 011 and 001 leave the state at S5. S3 is entered only from S0 or from the unused state.
- R3: A decoded state is taken only after it has been seen on two consecutive clocks. state_o changes on the fourth rising edge after an input change. A code that lasts one cycle is ignored.
- R4: dual_main_gate_o and dual_stby_gate_o are never high together.
- R5: When the dual rail moves from main to standby, both dual gates are low for exactly DEAD_M2S_CYC cycles.
- R6: When the dual rail moves from standby to main, both dual gates are low for exactly DEAD_S2M_CYC cycles.
- R7: When the adjustable rail moves between main and standby, both of its drives are high for exactly OVERLAP_CYC cycles, and the rail is never left without a drive.
- R8: Rail sources follow the state. The dual rail is fed from main in S0 and in the unused state, and from standby in S3 and S5. The adjustable rail is fed from main in S0 and from standby in S3, and is off in S5 and in the unused state. A switch from off, or to off, takes no overlap.
- R9: An undervoltage flag that stays high for FAULT_QUAL_CYC consecutive synchronized cycles while its rail is driven latches that rail's fault and turns its drives off. A flag that lasts one cycle less latches nothing.
- R10: A latched fault stays set through later state changes, until standby-good goes low. A fault on one rail leaves the other rail and main_en_o unaffected.
- R11: While stby_good_i is low, every gate, drive, enable and fault output is low, and the control inputs are ignored. Once it returns, the block is in S5 with the dual rail on standby.
- R12: During reset all outputs are low and state_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all timing windows are counted in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_good_i | input | 1 | Standby supply good |
| pwr_ok_i | input | 1 | Main power good |
| slp_s3_i | input | 1 | S3 sleep control, high when awake |
| slp_s5_i | input | 1 | S5 sleep control, high when awake |
| dual_uv_i | input | 1 | Dual rail undervoltage flag |
| adj_uv_i | input | 1 | Adjustable rail undervoltage flag |
| state_o | output | 2 | Power state: 0 S5, 1 S3, 2 S0, 3 unused |
| main_en_o | output | 1 | Main supply in use |
| dual_main_gate_o | output | 1 | Dual rail gate from the main supply |
| dual_stby_gate_o | output | 1 | Dual rail gate from the standby supply |
| adj_main_drv_o | output | 1 | Adjustable rail drive from main |
| adj_stby_drv_o | output | 1 | Adjustable rail drive from standby |
| dual_fault_o | output | 1 | Dual rail overcurrent fault latched |
| adj_fault_o | output | 1 | Adjustable rail overcurrent fault latched |

## Verification
All eight codes are applied from each of the three reachable states S5, S3 and S0. This separates the plain decode from the blocked S5-to-S3 path, and confirms the rail sources in every state. The handovers S0 to S3, S3 to S0 and S0 to S5 are watched cycle by cycle. Counting gap cycles and overlap cycles tells apart the two dead times and the overlap window. Undervoltage pulses one cycle shorter than the qualification window, and exactly as long as it, locate the fault threshold. A one-cycle code glitch, and a standby-good drop with active controls present, confirm the stability filter and the supply gate.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    PS_S5     = 2'd0,
    PS_S3     = 2'd1,
    PS_S0     = 2'd2,
    PS_UNUSED = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_STBY = 2'd2
  } src_e;

  // S3 codes are ignored while in S5: no direct S5 -> S3 path
  function automatic pstate_e decode_code(input logic [2:0] code, input pstate_e cur);
    pstate_e nxt;
    case (code)
      3'b111:                 nxt = PS_S0;
      3'b110:                 nxt = PS_UNUSED;
      3'b101, 3'b011, 3'b001: nxt = (cur == PS_S5) ? PS_S5 : PS_S3;
      default:                nxt = PS_S5;
    endcase
    return nxt;
  endfunction

  function automatic src_e dual_src(input pstate_e st);
    return (st == PS_S0 || st == PS_UNUSED) ? SRC_MAIN : SRC_STBY;
  endfunction

  function automatic src_e adj_src(input pstate_e st);
    src_e s;
    case (st)
      PS_S0:   s = SRC_MAIN;
      PS_S3:   s = SRC_STBY;
      default: s = SRC_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end

endmodule

// File: rtl/acpi_state_ctl.sv
module acpi_state_ctl
  import acpi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       good_i,
  input  logic [2:0] code_i,
  output pstate_e    state_o
);

  pstate_e state_q, prev_q, cand;

  assign cand = decode_code(code_i, state_q);

  // commit only after the candidate is seen on two consecutive edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_S5;
      prev_q  <= PS_S5;
    end else if (!good_i) begin
      state_q <= PS_S5;
      prev_q  <= PS_S5;
    end else begin
      prev_q <= cand;
      if (cand == prev_q && cand != state_q) state_q <= cand;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/acpi_dual_switch.sv
module acpi_dual_switch
  import acpi_seq_pkg::*;
#(
  parameter int M2S_CYC = 8,
  parameter int S2M_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  src_e tgt_i,
  input  logic fault_i,
  output logic main_o,
  output logic stby_o,
  output logic active_o
);

  localparam int MAXC = (M2S_CYC > S2M_CYC) ? M2S_CYC : S2M_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LIM_M2S = CW'(M2S_CYC - 1);
  localparam logic [CW-1:0] LIM_S2M = CW'(S2M_CYC - 1);

  typedef enum logic [1:0] {DS_MAIN, DS_STBY, DS_DEAD} dst_e;

  dst_e          st_q;
  logic          to_main_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = to_main_q ? LIM_S2M : LIM_M2S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= DS_STBY;
      to_main_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!good_i) begin
      st_q      <= DS_STBY;
      to_main_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      case (st_q)
        DS_MAIN: if (tgt_i == SRC_STBY) begin
          st_q      <= DS_DEAD;
          to_main_q <= 1'b0;
          cnt_q     <= '0;
        end
        DS_STBY: if (tgt_i == SRC_MAIN) begin
          st_q      <= DS_DEAD;
          to_main_q <= 1'b1;
          cnt_q     <= '0;
        end
        default: begin
          if (cnt_q == lim) st_q <= to_main_q ? DS_MAIN : DS_STBY;
          else              cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign main_o   = good_i && !fault_i && (st_q == DS_MAIN);
  assign stby_o   = good_i && !fault_i && (st_q == DS_STBY);
  assign active_o = (st_q != DS_DEAD);

endmodule

// File: rtl/acpi_adj_switch.sv
module acpi_adj_switch
  import acpi_seq_pkg::*;
#(
  parameter int OVL_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  src_e tgt_i,
  input  logic fault_i,
  output logic main_o,
  output logic stby_o,
  output logic active_o
);

  localparam int CW = $clog2(OVL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(OVL_CYC - 1);

  typedef enum logic [1:0] {AS_OFF, AS_MAIN, AS_STBY, AS_OVL} ast_e;

  ast_e          st_q;
  logic          to_main_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= AS_OFF;
      to_main_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!good_i) begin
      st_q      <= AS_OFF;
      to_main_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      case (st_q)
        AS_OFF: begin
          if (tgt_i == SRC_MAIN)      st_q <= AS_MAIN;
          else if (tgt_i == SRC_STBY) st_q <= AS_STBY;
        end
        AS_MAIN: begin
          if (tgt_i == SRC_OFF) st_q <= AS_OFF;
          else if (tgt_i == SRC_STBY) begin
            st_q      <= AS_OVL;
            to_main_q <= 1'b0;
            cnt_q     <= '0;
          end
        end
        AS_STBY: begin
          if (tgt_i == SRC_OFF) st_q <= AS_OFF;
          else if (tgt_i == SRC_MAIN) begin
            st_q      <= AS_OVL;
            to_main_q <= 1'b1;
            cnt_q     <= '0;
          end
        end
        default: begin
          if (tgt_i == SRC_OFF)  st_q  <= AS_OFF;
          else if (cnt_q == LIM) st_q  <= to_main_q ? AS_MAIN : AS_STBY;
          else                   cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign main_o   = good_i && !fault_i && (st_q == AS_MAIN || st_q == AS_OVL);
  assign stby_o   = good_i && !fault_i && (st_q == AS_STBY || st_q == AS_OVL);
  assign active_o = (st_q != AS_OFF);

endmodule

// File: rtl/acpi_uv_fault.sv
module acpi_uv_fault #(
  parameter int QUAL_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic uv_i,
  input  logic active_i,
  output logic fault_o
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!good_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q) begin
      if (uv_i && active_i) begin
        if (cnt_q == LIM) fault_q <= 1'b1;
        else              cnt_q   <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign fault_o = fault_q && good_i;

endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_seq_pkg::*;
#(
  parameter int DEAD_M2S_CYC   = 8,
  parameter int DEAD_S2M_CYC   = 1,
  parameter int OVERLAP_CYC    = 6,
  parameter int FAULT_QUAL_CYC = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_good_i,
  input  logic       pwr_ok_i,
  input  logic       slp_s3_i,
  input  logic       slp_s5_i,
  input  logic       dual_uv_i,
  input  logic       adj_uv_i,
  output logic [1:0] state_o,
  output logic       main_en_o,
  output logic       dual_main_gate_o,
  output logic       dual_stby_gate_o,
  output logic       adj_main_drv_o,
  output logic       adj_stby_drv_o,
  output logic       dual_fault_o,
  output logic       adj_fault_o
);

  localparam int NSYNC = 6;
  localparam int NRAIL = 2;  // 0: dual, 1: adjustable

  logic [NSYNC-1:0] raw, syn;
  logic             good_s;
  logic [2:0]       code_s;
  logic [NRAIL-1:0] uv_s, rail_active, fault;
  pstate_e          pstate;

  assign raw    = {adj_uv_i, dual_uv_i, slp_s5_i, slp_s3_i, pwr_ok_i, stby_good_i};
  assign good_s = syn[0];
  assign code_s = {syn[1], syn[2], syn[3]};
  assign uv_s   = syn[5:4];

  acpi_sync #(.WIDTH(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  acpi_state_ctl u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .good_i (good_s),
    .code_i (code_s),
    .state_o(pstate)
  );

  acpi_dual_switch #(
    .M2S_CYC(DEAD_M2S_CYC),
    .S2M_CYC(DEAD_S2M_CYC)
  ) u_dual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .good_i  (good_s),
    .tgt_i   (dual_src(pstate)),
    .fault_i (fault[0]),
    .main_o  (dual_main_gate_o),
    .stby_o  (dual_stby_gate_o),
    .active_o(rail_active[0])
  );

  acpi_adj_switch #(.OVL_CYC(OVERLAP_CYC)) u_adj (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .good_i  (good_s),
    .tgt_i   (adj_src(pstate)),
    .fault_i (fault[1]),
    .main_o  (adj_main_drv_o),
    .stby_o  (adj_stby_drv_o),
    .active_o(rail_active[1])
  );

  for (genvar i = 0; i < NRAIL; i++) begin : g_fault
    acpi_uv_fault #(.QUAL_CYC(FAULT_QUAL_CYC)) u_flt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .good_i  (good_s),
      .uv_i    (uv_s[i]),
      .active_i(rail_active[i]),
      .fault_o (fault[i])
    );
  end

  assign state_o      = pstate;
  assign main_en_o    = good_s && (pstate == PS_S0 || pstate == PS_UNUSED);
  assign dual_fault_o = fault[0];
  assign adj_fault_o  = fault[1];

endmodule

// File: rtl/acpi_pwr_seq_chk.sv
module acpi_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stby_good_i,
  input logic [1:0] state_o,
  input logic       main_en_o,
  input logic       dual_main_gate_o,
  input logic       dual_stby_gate_o,
  input logic       adj_main_drv_o,
  input logic       adj_stby_drv_o,
  input logic       dual_fault_o,
  input logic       adj_fault_o
);

  a_r1_main_en_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_en_o |-> state_o[1]);

  a_r2_no_s5_to_s3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_o) == 2'd0 |-> state_o != 2'd1);

  a_r4_dual_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dual_main_gate_o && dual_stby_gate_o));

  a_r5_dual_break_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dual_main_gate_o) |-> !dual_stby_gate_o);

  a_r7_adj_make_to_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adj_stby_drv_o) && $past(adj_main_drv_o) |-> adj_main_drv_o);

  a_r7_adj_make_to_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adj_main_drv_o) && $past(adj_stby_drv_o) |-> adj_stby_drv_o);

  a_r8_adj_off_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 || state_o == 2'd3) && $past(state_o) == state_o
      |-> !adj_main_drv_o && !adj_stby_drv_o);

  a_r9_adj_fault_cuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adj_fault_o) |-> $past(adj_main_drv_o || adj_stby_drv_o)
                           && !adj_main_drv_o && !adj_stby_drv_o);

  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dual_fault_o) || $fell(adj_fault_o) |-> $past(!stby_good_i, 2));

  a_r11_good_low_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_good_i && $past(!stby_good_i) && $past(!stby_good_i, 2)
      |-> !main_en_o && !dual_main_gate_o && !dual_stby_gate_o && !adj_main_drv_o
          && !adj_stby_drv_o && !dual_fault_o && !adj_fault_o);

endmodule

bind acpi_pwr_seq acpi_pwr_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .stby_good_i     (stby_good_i),
  .state_o         (state_o),
  .main_en_o       (main_en_o),
  .dual_main_gate_o(dual_main_gate_o),
  .dual_stby_gate_o(dual_stby_gate_o),
  .adj_main_drv_o  (adj_main_drv_o),
  .adj_stby_drv_o  (adj_stby_drv_o),
  .dual_fault_o    (dual_fault_o),
  .adj_fault_o     (adj_fault_o)
);

// File: tb/tb_acpi_pwr_seq.sv
module tb_acpi_pwr_seq;
  localparam int M2S  = 4;
  localparam int S2M  = 2;
  localparam int OVL  = 3;
  localparam int QUAL = 10;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni, good, pok, s3, s5, duv, auv;
  logic [1:0] state;
  logic       main_en, d_main, d_stby, a_main, a_stby, d_flt, a_flt;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  acpi_pwr_seq #(
    .DEAD_M2S_CYC(M2S), .DEAD_S2M_CYC(S2M), .OVERLAP_CYC(OVL), .FAULT_QUAL_CYC(QUAL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stby_good_i(good), .pwr_ok_i(pok),
    .slp_s3_i(s3), .slp_s5_i(s5), .dual_uv_i(duv), .adj_uv_i(auv),
    .state_o(state), .main_en_o(main_en), .dual_main_gate_o(d_main),
    .dual_stby_gate_o(d_stby), .adj_main_drv_o(a_main), .adj_stby_drv_o(a_stby),
    .dual_fault_o(d_flt), .adj_fault_o(a_flt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_code(input logic [2:0] c);
    {pok, s3, s5} = c;
  endtask

  function automatic int exp_next(input int cur, input logic [2:0] c);
    case (c)
      3'b111:                 return 2;
      3'b110:                 return 3;
      3'b101, 3'b011, 3'b001: return (cur == 0) ? 0 : 1;
      default:                return 0;
    endcase
  endfunction

  task automatic check_rails(input string req, input int st);
    chk(req, "state", int'(state), st);
    chk(req, "main_en", int'(main_en), int'(st >= 2));
    chk("R8", "dual_main", int'(d_main), int'(st >= 2));
    chk("R8", "dual_stby", int'(d_stby), int'(st < 2));
    chk("R8", "adj_main", int'(a_main), int'(st == 2));
    chk("R8", "adj_stby", int'(a_stby), int'(st == 1));
  endtask

  task automatic goto_state(input int st);
    set_code(3'b111); cyc(SETTLE);
    if (st == 1) begin set_code(3'b101); cyc(SETTLE); end
    if (st == 0) begin set_code(3'b000); cyc(SETTLE); end
  endtask

  task automatic watch(input int n, output int gap, output int both, output int aoff);
    gap = 0; both = 0; aoff = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!d_main && !d_stby) gap++;
      if (a_main && a_stby) both++;
      if (!a_main && !a_stby) aoff++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int gap, both, aoff;
    rst_ni = 1'b0; good = 1'b1; duv = 1'b0; auv = 1'b0;
    set_code(3'b000);
    cyc(3);
    // R12
    chk("R12", "state", int'(state), 0);
    chk("R12", "outputs", int'({main_en, d_main, d_stby, a_main, a_stby, d_flt, a_flt}), 0);
    rst_ni = 1'b1;
    cyc(3);
    check_rails("R12", 0);

    // R3 latency
    set_code(3'b111);
    cyc(3);
    chk("R3", "state before commit", int'(state), 0);
    cyc(1);
    chk("R3", "state at commit", int'(state), 2);
    cyc(SETTLE);
    check_rails("R1", 2);

    // R3 one-cycle glitch ignored
    set_code(3'b101); cyc(1); set_code(3'b111);
    cyc(10);
    chk("R3", "glitch state", int'(state), 2);
    chk("R3", "glitch dual_main", int'(d_main), 1);

    // R5 R7: S0 -> S3
    set_code(3'b101);
    watch(30, gap, both, aoff);
    chk("R5", "m2s gap", gap, M2S);
    chk("R7", "overlap to stby", both, OVL);
    chk("R7", "adj undriven", aoff, 0);
    check_rails("R1", 1);

    // R6 R7: S3 -> S0
    set_code(3'b111);
    watch(30, gap, both, aoff);
    chk("R6", "s2m gap", gap, S2M);
    chk("R7", "overlap to main", both, OVL);
    chk("R7", "adj undriven", aoff, 0);
    check_rails("R1", 2);

    // R5 R8: S0 -> S5
    set_code(3'b000);
    watch(30, gap, both, aoff);
    chk("R5", "m2s gap to S5", gap, M2S);
    chk("R8", "no overlap to off", both, 0);
    check_rails("R1", 0);

    // R2: S3 codes blocked in S5
    set_code(3'b001); cyc(SETTLE); check_rails("R2", 0);
    set_code(3'b101); cyc(SETTLE); check_rails("R2", 0);
    set_code(3'b011); cyc(SETTLE); check_rails("R2", 0);
    set_code(3'b111); cyc(SETTLE);
    set_code(3'b011); cyc(SETTLE); check_rails("R2", 1);

    // R1 R2 sweep from every reachable state
    for (int st = 0; st < 3; st++) begin
      for (int c = 0; c < 8; c++) begin
        goto_state(st);
        set_code(3'(c));
        cyc(SETTLE);
        check_rails((st == 0 && c[0] && c != 7) ? "R2" : "R1", exp_next(st, 3'(c)));
      end
    end

    // R9 fault threshold on the dual rail
    goto_state(2);
    duv = 1'b1; cyc(QUAL - 1); duv = 1'b0;
    cyc(5);
    chk("R9", "short uv fault", int'(d_flt), 0);
    chk("R9", "short uv dual_main", int'(d_main), 1);
    duv = 1'b1; cyc(QUAL); duv = 1'b0;
    cyc(5);
    chk("R9", "full uv fault", int'(d_flt), 1);
    chk("R9", "dual gates off", int'({d_main, d_stby}), 0);
    chk("R10", "adj unaffected", int'(a_main), 1);
    chk("R10", "adj fault clear", int'(a_flt), 0);
    chk("R10", "main_en unaffected", int'(main_en), 1);
    set_code(3'b101); cyc(SETTLE);
    chk("R10", "fault sticky", int'(d_flt), 1);
    chk("R10", "dual still off", int'({d_main, d_stby}), 0);
    chk("R10", "state S3", int'(state), 1);
    chk("R10", "adj on stby", int'(a_stby), 1);
    auv = 1'b1; cyc(QUAL + 4); auv = 1'b0;
    cyc(2);
    chk("R9", "adj fault", int'(a_flt), 1);
    chk("R9", "adj drives off", int'({a_main, a_stby}), 0);

    // R11 supply gate
    good = 1'b0; set_code(3'b111);
    cyc(SETTLE);
    chk("R11", "outputs off", int'({main_en, d_main, d_stby, a_main, a_stby, d_flt, a_flt}), 0);
    chk("R11", "state held S5", int'(state), 0);
    good = 1'b1;
    cyc(2);
    chk("R11", "restart state", int'(state), 0);
    chk("R11", "restart dual_stby", int'(d_stby), 1);
    chk("R11", "restart faults", int'({d_flt, a_flt}), 0);
    chk("R11", "restart main_en", int'(main_en), 0);
    cyc(SETTLE);
    check_rails("R1", 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule